// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block sits between two ports that share one memory. Each cycle it compares the two port addresses. When both ports are enabled and point at the same word, it raises a busy flag toward the port that arrived later and keeps that port's write strobe from reaching the memory. Reads are never blocked. Only the write enable is gated, and the address of each port always passes through to the memory.

A write that is refused while busy is not lost. It is parked in a one-entry buffer for that port, together with its address and data. It is issued to the memory in the first cycle in which the port's busy flag is low.

The block has two modes. In master mode it arbitrates by itself and drives the busy outputs. In slave mode it does no arbitration: the busy outputs stay low, and busy flags supplied by an external master on the busy inputs gate the writes instead. Both ports behave the same way, except for the tie-break described below.

Top module: `busy_arbiter`

The arbitration state machine has three states:
- `ARB_IDLE`: no contention.
- `ARB_A_OWNS`: port A won, so B is busy.
- `ARB_B_OWNS`: port B won, so A is busy.

Its transitions are:
- idle to A-owns, or idle to B-owns, on a new match, decided by arrival order.
- An owner state stays put while the match holds.
- Any state returns to idle when the match ends or when slave mode is selected.

Each port's write gate has two states:
- `WR_OPEN`: no held write.
- `WR_HELD`: one write is buffered.

Its transitions are:
- open to held when a request meets busy.
- held to held when a new request is captured.
- held to open when the buffer drains with no new request.

## Requirements
- R1: In master mode, when both chip enables are high and the addresses are equal, the port whose address arrived later gets its busy output high and the earlier port's busy output stays low. A port has "arrived" in a cycle if it was disabled in the previous cycle or its address differs from the previous cycle's value.
- R2: If both ports arrive in the same cycle with matching addresses, port A wins and only `b_busy_out` goes high.
- R3: Once a winner is chosen, it keeps the win for as long as the match continues without a break, even when neither port changes.
- R4: A busy output falls in the same cycle in which the addresses stop matching or either chip enable goes low.
- R5: While a port's effective busy is high (its busy output in master mode, its busy input in slave mode), its memory write enable stays low. The other port's write passes in the same cycle.
- R6: A write refused by busy is issued with its captured address and data in the first cycle in which that port's effective busy is low, and it is issued for exactly one cycle.
- R7: A new write request that arrives while a write is held and busy is still high replaces the held address and data.
- R8: In slave mode both busy outputs stay low, no local arbitration takes place, and the busy inputs alone gate the writes.
- R9: Each port's memory address equals its port address in every cycle except a drain cycle. Busy never blocks the address path, so reads are unaffected.
- R10: Reset clears both busy outputs, both held writes and both memory write enables.
- R11: If a new request arrives in the cycle a held write drains, the held write is issued first and the new one is issued in the next cycle in which busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1 selects slave mode (busy taken from inputs) |
| a_ce | input | 1 | Port A chip enable, active high |
| a_addr | input | ADDR_W | Port A address |
| a_wr_req | input | 1 | Port A write request (one per cycle) |
| a_wdata | input | DATA_W | Port A write data |
| a_busy_in | input | 1 | Port A busy from external master (slave mode) |
| a_busy_out | output | 1 | Port A busy driven in master mode |
| a_mem_we | output | 1 | Gated write enable to memory, port A |
| a_mem_addr | output | ADDR_W | Memory address, port A |
| a_mem_wdata | output | DATA_W | Memory write data, port A |
| b_ce | input | 1 | Port B chip enable, active high |
| b_addr | input | ADDR_W | Port B address |
| b_wr_req | input | 1 | Port B write request |
| b_wdata | input | DATA_W | Port B write data |
| b_busy_in | input | 1 | Port B busy from external master (slave mode) |
| b_busy_out | output | 1 | Port B busy driven in master mode |
| b_mem_we | output | 1 | Gated write enable to memory, port B |
| b_mem_addr | output | ADDR_W | Memory address, port B |
| b_mem_wdata | output | DATA_W | Memory write data, port B |

## Verification
Three events can fall in the same cycle: a held write draining because busy has just fallen, a fresh write request on the same port, and in some cases a new arbitration decision.

The bench provokes the first pair by raising a request in exactly the cycle in which the match is broken. It then judges that the buffered data goes out first and the fresh data one cycle later. It also lines up both ports' arrivals in one cycle to check the tie-break, and it checks that the winner's write passes in the very cycle in which the loser's write is refused.

// File: rtl/busy_arb_pkg.sv
package busy_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_A_OWNS = 2'd1,
        ARB_B_OWNS = 2'd2
    } arb_state_t;

    typedef enum logic {
        WR_OPEN = 1'b0,
        WR_HELD = 1'b1
    } wr_state_t;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/busy_arb_match.sv
module busy_arb_match #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_ce,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              b_ce,
    input  logic [ADDR_W-1:0] b_addr,
    output logic              match,
    output logic              a_new,
    output logic              b_new
);
    logic              a_ce_q;
    logic              b_ce_q;
    logic [ADDR_W-1:0] a_addr_q;
    logic [ADDR_W-1:0] b_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_ce_q   <= 1'b0;
            b_ce_q   <= 1'b0;
            a_addr_q <= '0;
            b_addr_q <= '0;
        end else begin
            a_ce_q   <= a_ce;
            b_ce_q   <= b_ce;
            a_addr_q <= a_addr;
            b_addr_q <= b_addr;
        end
    end

    always_comb begin
        match = a_ce && b_ce && (a_addr == b_addr);
        a_new = !a_ce_q || (a_addr != a_addr_q);
        b_new = !b_ce_q || (b_addr != b_addr_q);
    end
endmodule

// File: rtl/busy_arb_master_fsm.sv
module busy_arb_master_fsm
    import busy_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slave_mode,
    input  logic match,
    input  logic a_new,
    input  logic b_new,
    output logic a_busy,
    output logic b_busy
);
    arb_state_t state_q;
    arb_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (slave_mode || !match) begin
            state_d = ARB_IDLE;
        end else begin
            unique case (state_q)
                ARB_IDLE:   state_d = (a_new && !b_new) ? ARB_B_OWNS : ARB_A_OWNS;
                ARB_A_OWNS: state_d = ARB_A_OWNS;
                ARB_B_OWNS: state_d = ARB_B_OWNS;
                default:    state_d = ARB_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        a_busy = 1'b0;
        b_busy = 1'b0;
        unique case (state_d)
            ARB_IDLE:   ;
            ARB_A_OWNS: b_busy = 1'b1;
            ARB_B_OWNS: a_busy = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/busy_arb_wr_gate.sv
module busy_arb_wr_gate
    import busy_arb_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    wr_state_t         state_q;
    wr_state_t         state_d;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [DATA_W-1:0] hold_data_q;
    logic              capture;
    logic              drain;

    always_comb begin
        drain   = (state_q == WR_HELD) && !busy;
        capture = wr_req && (busy || state_q == WR_HELD);
        state_d = state_q;
        unique case (state_q)
            WR_OPEN: if (capture) state_d = WR_HELD;
            WR_HELD: if (!capture && drain) state_d = WR_OPEN;
            default: state_d = WR_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= WR_OPEN;
            hold_addr_q <= '0;
            hold_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (capture) begin
                hold_addr_q <= addr;
                hold_data_q <= wdata;
            end
        end
    end

    always_comb begin
        mem_we    = drain || (state_q == WR_OPEN && wr_req && !busy);
        mem_addr  = drain ? hold_addr_q : addr;
        mem_wdata = drain ? hold_data_q : wdata;
    end
endmodule

// File: rtl/busy_arbiter.sv
module busy_arbiter
    import busy_arb_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              a_ce,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr_req,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_busy_in,
    output logic              a_busy_out,
    output logic              a_mem_we,
    output logic [ADDR_W-1:0] a_mem_addr,
    output logic [DATA_W-1:0] a_mem_wdata,
    input  logic              b_ce,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr_req,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_busy_in,
    output logic              b_busy_out,
    output logic              b_mem_we,
    output logic [ADDR_W-1:0] b_mem_addr,
    output logic [DATA_W-1:0] b_mem_wdata
);
    logic match;
    logic a_new;
    logic b_new;
    logic a_arb_busy;
    logic b_arb_busy;

    logic [NUM_PORTS-1:0]             busy_eff;
    logic [NUM_PORTS-1:0]             req_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0] data_v;
    logic [NUM_PORTS-1:0]             we_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] maddr_v;
    logic [NUM_PORTS-1:0][DATA_W-1:0] mdata_v;

    busy_arb_match #(.ADDR_W(ADDR_W)) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_ce   (a_ce),
        .a_addr (a_addr),
        .b_ce   (b_ce),
        .b_addr (b_addr),
        .match  (match),
        .a_new  (a_new),
        .b_new  (b_new)
    );

    busy_arb_master_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .match      (match),
        .a_new      (a_new),
        .b_new      (b_new),
        .a_busy     (a_arb_busy),
        .b_busy     (b_arb_busy)
    );

    always_comb begin
        a_busy_out  = a_arb_busy;
        b_busy_out  = b_arb_busy;
        busy_eff[0] = slave_mode ? a_busy_in : a_arb_busy;
        busy_eff[1] = slave_mode ? b_busy_in : b_arb_busy;
        req_v[0]    = a_wr_req;
        req_v[1]    = b_wr_req;
        addr_v[0]   = a_addr;
        addr_v[1]   = b_addr;
        data_v[0]   = a_wdata;
        data_v[1]   = b_wdata;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        busy_arb_wr_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .busy      (busy_eff[p]),
            .wr_req    (req_v[p]),
            .addr      (addr_v[p]),
            .wdata     (data_v[p]),
            .mem_we    (we_v[p]),
            .mem_addr  (maddr_v[p]),
            .mem_wdata (mdata_v[p])
        );
    end

    always_comb begin
        a_mem_we    = we_v[0];
        a_mem_addr  = maddr_v[0];
        a_mem_wdata = mdata_v[0];
        b_mem_we    = we_v[1];
        b_mem_addr  = maddr_v[1];
        b_mem_wdata = mdata_v[1];
    end
endmodule

// File: rtl/busy_arb_chk.sv
module busy_arb_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              a_ce,
    input logic [ADDR_W-1:0] a_addr,
    input logic              b_ce,
    input logic [ADDR_W-1:0] b_addr,
    input logic              a_busy_in,
    input logic              b_busy_in,
    input logic              a_busy_out,
    input logic              b_busy_out,
    input logic              a_mem_we,
    input logic              b_mem_we
);
    logic same_word;
    assign same_word = a_ce && b_ce && (a_addr == b_addr);

    // R1
    one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_busy_out && b_busy_out));

    // R4
    busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_busy_out || b_busy_out) |-> same_word);

    // R3
    owner_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_busy_out |=> !a_busy_out);

    // R8
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (!a_busy_out && !b_busy_out));

    // R5
    a_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode ? a_busy_in : a_busy_out) |-> !a_mem_we);

    // R5
    b_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode ? b_busy_in : b_busy_out) |-> !b_mem_we);
endmodule

bind busy_arbiter busy_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .a_ce       (a_ce),
    .a_addr     (a_addr),
    .b_ce       (b_ce),
    .b_addr     (b_addr),
    .a_busy_in  (a_busy_in),
    .b_busy_in  (b_busy_in),
    .a_busy_out (a_busy_out),
    .b_busy_out (b_busy_out),
    .a_mem_we   (a_mem_we),
    .b_mem_we   (b_mem_we)
);

// File: tb/busy_arbiter_tb.sv
module busy_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic          a_ce = 1'b0, b_ce = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic          a_wr_req = 1'b0, b_wr_req = 1'b0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic          a_busy_in = 1'b0, b_busy_in = 1'b0;
    logic          a_busy_out, b_busy_out, a_mem_we, b_mem_we;
    logic [AW-1:0] a_mem_addr, b_mem_addr;
    logic [DW-1:0] a_mem_wdata, b_mem_wdata;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busy_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .a_ce(a_ce), .a_addr(a_addr), .a_wr_req(a_wr_req), .a_wdata(a_wdata),
        .a_busy_in(a_busy_in), .a_busy_out(a_busy_out), .a_mem_we(a_mem_we),
        .a_mem_addr(a_mem_addr), .a_mem_wdata(a_mem_wdata),
        .b_ce(b_ce), .b_addr(b_addr), .b_wr_req(b_wr_req), .b_wdata(b_wdata),
        .b_busy_in(b_busy_in), .b_busy_out(b_busy_out), .b_mem_we(b_mem_we),
        .b_mem_addr(b_mem_addr), .b_mem_wdata(b_mem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // advance to the next negative edge, leave a settle gap for checks
    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic go_idle();
        step();
        a_ce = 0; b_ce = 0; a_wr_req = 0; b_wr_req = 0;
        a_busy_in = 0; b_busy_in = 0; slave_mode = 0;
        step();
    endtask

    task automatic t_reset();
        settle();
        chk("R10 a_busy", a_busy_out, 0);
        chk("R10 b_busy", b_busy_out, 0);
        chk("R10 a_we", a_mem_we, 0);
        chk("R10 b_we", b_mem_we, 0);
    endtask

    task automatic t_a_first();
        step(); a_ce = 1; a_addr = 5; b_ce = 1; b_addr = 9;
        step(); b_addr = 5; b_wr_req = 1; b_wdata = 18'h0AB; a_wr_req = 1; a_wdata = 18'h055;
        settle();
        chk("R1 b_busy", b_busy_out, 1);
        chk("R1 a_busy", a_busy_out, 0);
        chk("R5 b_we blocked", b_mem_we, 0);
        chk("R5 a_we passes", a_mem_we, 1);
        chk("R9 b_mem_addr", b_mem_addr, 5);
        step(); a_wr_req = 0; b_wr_req = 0;
        settle();
        chk("R3 b_busy kept", b_busy_out, 1);
        chk("R6 no early drain", b_mem_we, 0);
        step(); a_addr = 6;
        settle();
        chk("R4 busy falls", b_busy_out, 0);
        chk("R6 drain we", b_mem_we, 1);
        chk("R6 drain addr", b_mem_addr, 5);
        chk("R6 drain data", b_mem_wdata, 18'h0AB);
        step(); settle();
        chk("R6 single cycle", b_mem_we, 0);
        go_idle();
    endtask

    task automatic t_b_first();
        step(); b_ce = 1; b_addr = 7; a_ce = 1; a_addr = 3;
        step(); a_addr = 7;
        settle();
        chk("R1 a_busy", a_busy_out, 1);
        chk("R1 b_busy", b_busy_out, 0);
        step(); b_ce = 0;
        settle();
        chk("R4 ce drop", a_busy_out, 0);
        go_idle();
    endtask

    task automatic t_tie();
        step(); a_ce = 1; b_ce = 1; a_addr = 1; b_addr = 2;
        step(); a_addr = 40; b_addr = 40;
        settle();
        chk("R2 tie b_busy", b_busy_out, 1);
        chk("R2 tie a_busy", a_busy_out, 0);
        go_idle();
    endtask

    task automatic t_slave();
        step(); slave_mode = 1; a_ce = 1; b_ce = 1; a_addr = 8; b_addr = 9;
        step(); b_addr = 8; a_busy_in = 1; a_wr_req = 1; a_wdata = 18'h011;
        b_wr_req = 1; b_wdata = 18'h0CC;
        settle();
        chk("R8 a_busy_out low", a_busy_out, 0);
        chk("R8 b_busy_out low", b_busy_out, 0);
        chk("R8 a held", a_mem_we, 0);
        chk("R8 b passes", b_mem_we, 1);
        step(); b_wr_req = 0; a_wr_req = 1; a_addr = 12; a_wdata = 18'h022;
        settle();
        chk("R9 a addr follows", a_mem_addr, 12);
        step(); a_wr_req = 0; a_busy_in = 0;
        settle();
        chk("R7 drain we", a_mem_we, 1);
        chk("R7 replaced data", a_mem_wdata, 18'h022);
        chk("R7 replaced addr", a_mem_addr, 12);
        go_idle();
    endtask

    task automatic t_drain_and_new();
        step(); a_ce = 1; b_ce = 1; a_addr = 20; b_addr = 21;
        step(); b_addr = 20; b_wr_req = 1; b_wdata = 18'h0A1;
        step(); b_wr_req = 0;
        step(); a_addr = 22; b_wr_req = 1; b_addr = 30; b_wdata = 18'h0B2;
        settle();
        chk("R11 old first", b_mem_wdata, 18'h0A1);
        chk("R11 old we", b_mem_we, 1);
        step(); b_wr_req = 0;
        settle();
        chk("R11 new we", b_mem_we, 1);
        chk("R11 new data", b_mem_wdata, 18'h0B2);
        chk("R11 new addr", b_mem_addr, 30);
        step(); settle();
        chk("R11 done", b_mem_we, 0);
        go_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1;
        t_a_first();
        t_b_first();
        t_tie();
        t_slave();
        t_drain_and_new();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule